// File: doc/BRIEF.md
# Character Overlay Generator

This block lays a grid of text over a video picture. A dot clock runs it, and the horizontal and vertical sync inputs time it. Each cell of an 8-row by 20-column grid holds a 7-bit character code. The code picks one of 128 glyphs from a writable pattern store. Every glyph is 11 dots wide and 15 lines tall. On each video line the block works out which cell and which glyph line lie under the current dot and looks up that dot. It then drives separate red, green, blue and blank outputs.

Colour is set per text row, not per character. One chosen row can be split at a programmable column, so it shows two colours side by side and can draw a level bar. The dot timing freezes shortly after each horizontal sync begins and restarts a fixed time after it ends, so every line starts in the same phase. A single write port loads the control registers, the character cells, the glyph lines and the row colours.

Top module: `osd_gen`

## Requirements
- R1: While reset is held and right after it, blank_o, red_o, green_o and blue_o are all low, and the display is disabled.
- R2: With the display enabled, blank_o is high for exactly the dots hstart to hstart+219 of the lines vstart to vstart+119, and low everywhere else. With the display disabled, blank_o is low on every dot.
- R3: Take the dot at offset x = dot-hstart and line offset y = line-vstart inside the grid. It lies in cell row y/15, column x/11, glyph line y%15 and dot d = x%11. Its value is bit (10-d) of that glyph line, so bit 10 is the leftmost dot. The glyph used is the one named by the code stored for that cell.
- R4: Where the selected glyph dot is 1, {red_o,green_o,blue_o} shows the 3-bit colour of that cell's row, coded as {red,green,blue} in bits 2..0. Where the dot is 0, or outside the grid, all three are low.
- R5: When the bar mode is on, cells of the bar row whose column is greater than or equal to the boundary column use the bar colour. Cells to the left of the boundary keep the row colour. A boundary of 0 colours the whole row, a boundary of 20 or more colours none of it, and other rows are never affected.
- R6: Count the first clock edge that samples HSYNC high as edge 1. The output after edge 2 still shows the next dot of the line. After edge 3, and until the restart, all four outputs are low.
- R7: Count the first clock edge that samples HSYNC low as edge 1. Dot 0 of the line appears on the outputs after edge 3, and dot h appears after edge h+3, whatever length the previous line had.
- R8: A high VSYNC clears the line count. The first line whose restart comes after VSYNC has gone low is line 0, and each later restart adds one. Lines before the first VSYNC after reset show nothing.
- R9: The write port selects its target with wr_space. Space 0 is control: address 0 holds bit 0 display enable and bit 1 bar mode, address 1 hstart, address 2 vstart, address 3 bar row, address 4 bar boundary column and address 5 bar colour. Space 1 is a character cell at address row*20+col. Space 2 is a glyph line at address code*16+line. Space 3 is a row colour at address row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, active high, synchronous to clk |
| vsync | input | 1 | Vertical sync, active high, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| wr_space | input | 2 | Write target: control, cell, glyph line, row colour |
| wr_addr | input | 11 | Write address within the target |
| wr_data | input | 11 | Write data |
| red_o | output | 1 | Red dot |
| green_o | output | 1 | Green dot |
| blue_o | output | 1 | Blue dot |
| blank_o | output | 1 | High across the character area |

## Verification
The assertions check on every cycle that colour never shows without blank. They also check that a disabled display stays dark, that the outputs go dark and the dot counter holds once HSYNC has been high for a few cycles, that the counter starts at zero when timing restarts, and that VSYNC clears the line count. Only the bench scenarios can show the rest. These cover the exact placement of the grid, the cell and glyph-line lookup with its bit order, the row colours and the split of the bar row at its boundary, including the boundaries 0 and 20. They also cover the exact edge on which the first dot of a line appears after a sync pulse, across lines of different length.

// File: rtl/osd_gen.sv
module osd_gen #(
  parameter int ROWS   = 8,
  parameter int COLS   = 20,
  parameter int GW     = 11,
  parameter int GH     = 15,
  parameter int CODE_W = 7,
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 10,
  parameter int LINE_W = $clog2(GH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hsync,
  input  logic                     vsync,
  input  logic                     wr_en,
  input  logic [1:0]               wr_space,
  input  logic [CODE_W+LINE_W-1:0] wr_addr,
  input  logic [GW-1:0]            wr_data,
  output logic                     red_o,
  output logic                     green_o,
  output logic                     blue_o,
  output logic                     blank_o
);

  localparam int NCELL  = ROWS * COLS;
  localparam int NGLYPH = 1 << CODE_W;
  localparam int AW     = CODE_W + LINE_W;
  localparam int CELL_W = $clog2(NCELL);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int DOT_W  = $clog2(GW);
  localparam logic [HCNT_W-1:0] GRID_WV = HCNT_W'(COLS * GW);
  localparam logic [VCNT_W-1:0] GRID_HV = VCNT_W'(ROWS * GH);
  localparam logic [HCNT_W-1:0] GW_V    = HCNT_W'(GW);
  localparam logic [VCNT_W-1:0] GH_V    = VCNT_W'(GH);
  localparam logic [HCNT_W-1:0] HMAX    = {HCNT_W{1'b1}};
  localparam logic [VCNT_W-1:0] VMAX    = {VCNT_W{1'b1}};

  // control state
  logic              disp_en, bar_en;
  logic [HCNT_W-1:0] hstart;
  logic [VCNT_W-1:0] vstart;
  logic [ROW_W-1:0]  bar_row;
  logic [COL_W:0]    bar_col;
  logic [2:0]        bar_rgb;
  logic [2:0]        row_rgb [ROWS];

  // display memories
  logic [CODE_W-1:0] char_mem  [NCELL];
  logic [GW-1:0]     glyph_mem [NGLYPH][GH];

  // timing state
  logic              hs_q, rise_d1, fall_d1, running, vvalid;
  logic [HCNT_W-1:0] hcount;
  logic [VCNT_W-1:0] vcount;

  logic [CODE_W-1:0] wr_code;
  logic [LINE_W-1:0] wr_line;
  assign wr_code = wr_addr[AW-1 -: CODE_W];
  assign wr_line = wr_addr[LINE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_en <= 1'b0;
      bar_en  <= 1'b0;
      hstart  <= '0;
      vstart  <= '0;
      bar_row <= '0;
      bar_col <= '0;
      bar_rgb <= '0;
      for (int r = 0; r < ROWS; r++) row_rgb[r] <= 3'b111;
    end else if (wr_en) begin
      if (wr_space == 2'd0) begin
        case (wr_addr[2:0])
          3'd0: begin disp_en <= wr_data[0]; bar_en <= wr_data[1]; end
          3'd1: hstart  <= wr_data[HCNT_W-1:0];
          3'd2: vstart  <= wr_data[VCNT_W-1:0];
          3'd3: bar_row <= wr_data[ROW_W-1:0];
          3'd4: bar_col <= wr_data[COL_W:0];
          3'd5: bar_rgb <= wr_data[2:0];
          default: ;
        endcase
      end else if (wr_space == 2'd3 && int'(wr_addr) < ROWS) begin
        row_rgb[wr_addr[ROW_W-1:0]] <= wr_data[2:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_space == 2'd1 && int'(wr_addr) < NCELL)
      char_mem[wr_addr[CELL_W-1:0]] <= wr_data[CODE_W-1:0];
    if (wr_en && wr_space == 2'd2 && int'(wr_line) < GH)
      glyph_mem[wr_code][wr_line] <= wr_data;
  end

  logic hs_rise, hs_fall;
  assign hs_rise = hsync & ~hs_q;
  assign hs_fall = ~hsync & hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      rise_d1 <= 1'b0;
      fall_d1 <= 1'b0;
      running <= 1'b0;
      hcount  <= '0;
    end else begin
      hs_q    <= hsync;
      rise_d1 <= hs_rise;
      fall_d1 <= hs_fall;
      if (fall_d1) begin
        running <= 1'b1;
        hcount  <= '0;
      end else begin
        if (rise_d1) running <= 1'b0;
        if (running && hcount != HMAX) hcount <= hcount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcount <= '0;
      vvalid <= 1'b0;
    end else if (vsync) begin
      vcount <= '0;
      vvalid <= 1'b0;
    end else if (fall_d1) begin
      if (!vvalid) vvalid <= 1'b1;
      else if (vcount != VMAX) vcount <= vcount + 1'b1;
    end
  end

  // cell and glyph addressing
  logic [HCNT_W-1:0] xoff;
  logic [VCNT_W-1:0] yoff;
  logic              in_x, in_y, area;
  logic [COL_W-1:0]  col_n;
  logic [DOT_W-1:0]  dot_n;
  logic [ROW_W-1:0]  row_n;
  logic [LINE_W-1:0] line_n;
  logic [CELL_W-1:0] cell_idx;
  logic [CODE_W-1:0] code;
  logic [GW-1:0]     pat;
  logic              dot_on, bar_hit;
  logic [2:0]        colour;

  assign xoff     = hcount - hstart;
  assign yoff     = vcount - vstart;
  assign in_x     = (hcount >= hstart) && (xoff < GRID_WV);
  assign in_y     = (vcount >= vstart) && (yoff < GRID_HV);
  assign area     = disp_en && running && vvalid && in_x && in_y;
  assign col_n    = COL_W'(xoff / GW_V);
  assign dot_n    = DOT_W'(xoff % GW_V);
  assign row_n    = ROW_W'(yoff / GH_V);
  assign line_n   = LINE_W'(yoff % GH_V);
  assign cell_idx = CELL_W'(int'(row_n) * COLS + int'(col_n));
  assign code     = char_mem[cell_idx];
  assign pat      = glyph_mem[code][line_n];
  assign dot_on   = pat[DOT_W'(GW - 1) - dot_n];
  assign bar_hit  = bar_en && (row_n == bar_row) && ({1'b0, col_n} >= bar_col);
  assign colour   = bar_hit ? bar_rgb : row_rgb[row_n];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_o <= 1'b0;
      {red_o, green_o, blue_o} <= 3'b000;
    end else begin
      blank_o <= area;
      {red_o, green_o, blue_o} <= (area && dot_on) ? colour : 3'b000;
    end
  end

endmodule

// File: rtl/osd_gen_chk.sv
module osd_gen_chk #(
  parameter int HCNT_W = 10,
  parameter int VCNT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync,
  input logic              vsync,
  input logic              red_o,
  input logic              green_o,
  input logic              blue_o,
  input logic              blank_o,
  input logic              running,
  input logic              fall_d1,
  input logic              disp_en,
  input logic [HCNT_W-1:0] hcount,
  input logic [VCNT_W-1:0] vcount
);

  p_colour_inside_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (red_o || green_o || blue_o) |-> blank_o);

  p_off_is_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_en) |-> !blank_o);

  p_dark_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && $past(hsync) && $past(hsync, 2)) |=> (!blank_o && !red_o && !green_o && !blue_o));

  p_frozen_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && $past(!running)) |-> $stable(hcount));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fall_d1) |-> (hcount == '0 && running));

  p_vsync_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vsync) |-> vcount == '0);

endmodule

bind osd_gen osd_gen_chk #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
  .red_o(red_o), .green_o(green_o), .blue_o(blue_o), .blank_o(blank_o),
  .running(running), .fall_d1(fall_d1), .disp_en(disp_en),
  .hcount(hcount), .vcount(vcount)
);

// File: tb/osd_gen_tb.sv
module osd_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 8, COLS = 20, GW = 11, GH = 15;
  localparam int GRID_W = COLS * GW, GRID_H = ROWS * GH;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b1, vsync = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_space = '0;
  logic [10:0] wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic red_o, green_o, blue_o, blank_o;

  osd_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .wr_en(wr_en), .wr_space(wr_space), .wr_addr(wr_addr), .wr_data(wr_data),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o), .blank_o(blank_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0, cur_line = -1;
  bit done = 0;

  bit        sh_en, sh_bar;
  int        sh_hs, sh_vs, sh_brow, sh_bcol;
  bit [2:0]  sh_bcolour;
  bit [2:0]  sh_row [ROWS];
  bit [6:0]  sh_char [ROWS*COLS];
  bit [10:0] sh_glyph [128][GH];

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s line %0d: actual %b expected %b", tag, cur_line, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_space = sp; wr_addr = 11'(addr); wr_data = 11'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input bit en, input bit bar);
    sh_en = en; sh_bar = bar;
    wr(2'd0, 0, {bar, en});
  endtask

  task automatic set_pos(input int hs, input int vs);
    sh_hs = hs; sh_vs = vs;
    wr(2'd0, 1, hs);
    wr(2'd0, 2, vs);
  endtask

  task automatic set_bar(input int brow, input int bcol, input bit [2:0] c);
    sh_brow = brow; sh_bcol = bcol; sh_bcolour = c;
    wr(2'd0, 3, brow);
    wr(2'd0, 4, bcol);
    wr(2'd0, 5, c);
  endtask

  task automatic put_char(input int r, input int c, input int code);
    sh_char[r*COLS+c] = 7'(code);
    wr(2'd1, r*COLS + c, code);
  endtask

  task automatic put_glyph(input int code, input int ln, input bit [10:0] v);
    sh_glyph[code][ln] = v;
    wr(2'd2, code*16 + ln, v);
  endtask

  task automatic put_rowcol(input int r, input bit [2:0] c);
    sh_row[r] = c;
    wr(2'd3, r, c);
  endtask

  function automatic logic [3:0] exp_pix(input int h, input int v);
    int row, ln, col, d;
    bit [10:0] pat;
    bit [2:0] c;
    if (!sh_en || v < 0 || v < sh_vs || v >= sh_vs + GRID_H || h < sh_hs || h >= sh_hs + GRID_W)
      return 4'b0000;
    row = (v - sh_vs) / GH; ln = (v - sh_vs) % GH;
    col = (h - sh_hs) / GW; d = (h - sh_hs) % GW;
    pat = sh_glyph[sh_char[row*COLS+col]][ln];
    if (!pat[10-d]) return 4'b1000;
    c = (sh_bar && row == sh_brow && col >= sh_bcol) ? sh_bcolour : sh_row[row];
    return {1'b1, c};
  endfunction

  // one line: HSYNC low, ndots dots, then the next HSYNC pulse (R6, R7)
  task automatic do_line(input int ndots, input bit check, input string tb, input string tc);
    logic [3:0] e;
    @(negedge clk);
    hsync = 1'b0;
    repeat (3) @(negedge clk);
    for (int h = 0; h < ndots; h++) begin
      if (check) begin
        e = exp_pix(h, cur_line);
        chk(tb, {blank_o, 3'b000}, {e[3], 3'b000});
        chk(tc, {1'b0, red_o, green_o, blue_o}, {1'b0, e[2:0]});
      end
      @(negedge clk);
    end
    hsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (check) chk("R6 dot still shown", {blank_o, red_o, green_o, blue_o}, exp_pix(ndots + 2, cur_line));
    @(negedge clk);
    if (check) chk("R6 dark in sync", {blank_o, red_o, green_o, blue_o}, 4'b0000);
    repeat (3) @(negedge clk);
    if (cur_line >= 0) cur_line++;
  endtask

  task automatic do_vsync();
    @(negedge clk);
    vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
    cur_line = 0;
  endtask

  function automatic bit [10:0] gpat(input int c, input int l);
    return 11'((c * 157 + l * 293 + (c ^ l) * 41) ^ (l << (c % 5)));
  endfunction

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 in reset", {blank_o, red_o, green_o, blue_o}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", {blank_o, red_o, green_o, blue_o}, 4'b0000);
    for (int r = 0; r < ROWS; r++) sh_row[r] = 3'b111;
    do_line(60, 1'b1, "R1 R8 no vsync yet", "R1 R8 no vsync yet");
  endtask

  task automatic t_load();
    for (int c = 0; c < 7; c++)
      for (int l = 0; l < GH; l++)
        put_glyph(c, l, (c == 6) ? 11'h7ff : gpat(c, l));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        put_char(r, c, (r * 3 + c) % 6);
    for (int r = 0; r < ROWS; r++) put_rowcol(r, 3'((r % 7) + 1));
    set_pos(5, 2);
  endtask

  task automatic t_disabled();
    set_ctrl(1'b0, 1'b0);
    do_vsync();
    for (int i = 0; i < 6; i++) do_line(228, 1'b1, "R2 disabled", "R2 disabled");
  endtask

  task automatic t_frame();
    set_ctrl(1'b1, 1'b0);
    do_vsync();
    for (int i = 0; i < sh_vs + GRID_H + 1; i++)
      do_line(sh_hs + GRID_W + 3, 1'b1, "R2 R7 R8 R9 blank", "R3 R4 R9 colour");
  endtask

  task automatic t_bar(input int bcol);
    set_bar(3, bcol, 3'b101);
    set_ctrl(1'b1, 1'b1);
    do_vsync();
    for (int i = 0; i < sh_vs + 4 * GH + 1; i++)
      do_line(sh_hs + GRID_W + 3, 1'b1, "R5 blank", "R5 bar colour");
  endtask

  task automatic t_short();
    set_ctrl(1'b1, 1'b0);
    set_pos(5, 0);
    for (int c = 0; c < COLS; c++) put_char(0, c, 6);
    do_vsync();
    do_line(40, 1'b1, "R6 R7 short", "R6 R7 short");
    do_line(23, 1'b1, "R6 R7 short", "R6 R7 short");
    do_line(90, 1'b1, "R6 R7 short", "R6 R7 short");
  endtask

  initial begin
    t_reset();
    t_load();
    t_disabled();
    t_frame();
    t_bar(9);
    t_bar(0);
    t_bar(20);
    t_short();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule